// File: doc/BRIEF.md
# Destination Address Filter with Loadable Match Table

This block decides whether an incoming Ethernet frame is accepted. It looks only at the 48-bit destination address, which arrives as one parallel word with a valid strobe. The address is tested against a fixed-priority chain of rules:

1. Promiscuous mode accepts unicast addresses.
2. Accept-all-multicast mode accepts group addresses.
3. Broadcast mode accepts the all-ones address.
4. A 16-entry match table accepts an address that equals one of its enabled entries.

The verdict and its type flags are registered and appear one cycle after the strobe.

The match table is filled by a loader that consumes a stream of 16-bit words fetched from memory elsewhere. A load command carries an entry count. The loader then takes one four-word record per entry and stores each record as a table entry. A final record supplies the enable mask. When that record is done, the loader drops its busy flag and raises a sticky done flag. While the controller is held in its reset mode, the host can inspect any table entry through three 16-bit read ports.

Top module: `dest_addr_filter`

## Requirements
- R1: When `cfg_promisc` is 1 and bit 0 of address byte 0 (`dst_addr[0]`) is 0, the frame is accepted with `dec_mcast` and `dec_bcast` both 0.
- R2: Otherwise, when `cfg_all_mcast` is 1 and `dst_addr[0]` is 1, the frame is accepted with `dec_mcast`=1 and `dec_bcast`=0. This holds even for the all-ones address with broadcast enabled.
- R3: Otherwise, when `cfg_bcast` is 1 and `dst_addr` is all ones, the frame is accepted with `dec_bcast`=1 and `dec_mcast`=0.
- R4: Otherwise, the frame is accepted with no flag if it equals an enabled table entry, and rejected (all three outputs 0) if no enabled entry matches. Byte i of the address is `dst_addr[8i+7:8i]`.
- R5: A table entry whose bit in the enable mask is 0 never causes acceptance.
- R6: `dec_vld` is 1 in exactly the cycle after a cycle with `dst_vld`=1. The type flags are never 1 without `dec_accept`.
- R7: Each record is four consecutive words. Word 0 is ignored, and words 1, 2 and 3 give address bytes {0,1}, {2,3} and {4,5}, low byte first (the word's bits [7:0] are the lower-numbered byte).
- R8: `ld_start` loads `ld_count` (5 bits) entries into indices 0, 1, 2 and onward. A count of 0 loads no entry and reads only the mask record.
- R9: After the entry records, one more record is read. Its word 0 becomes the enable mask, with bit i enabling entry i. At the end of that record `ld_busy` falls and `ld_done` rises in the same cycle. `ld_done` stays set until `ld_done_clr` is pulsed, and `ld_start` is ignored while busy.
- R10: While `cfg_in_reset` is 1, `rd_w0`, `rd_w1` and `rd_w2` return bytes {0,1}, {2,3} and {4,5} of entry `rd_sel`, low byte first. Otherwise all three read ports are 0.
- R11: After reset, `ld_busy`, `ld_done`, `dec_vld`, `dec_accept` and the flags are 0, and the enable mask is 0, so every frame is rejected in the table stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_promisc | input | 1 | Promiscuous unicast mode |
| cfg_all_mcast | input | 1 | Accept every group address |
| cfg_bcast | input | 1 | Accept the all-ones address |
| cfg_in_reset | input | 1 | Controller reset mode; enables the read ports |
| dst_vld | input | 1 | Destination address valid |
| dst_addr | input | 48 | Destination address, byte i in bits [8i+7:8i] |
| dec_vld | output | 1 | Verdict valid |
| dec_accept | output | 1 | Frame accepted |
| dec_mcast | output | 1 | Accepted as multicast |
| dec_bcast | output | 1 | Accepted as broadcast |
| ld_start | input | 1 | Load command |
| ld_count | input | 5 | Number of entry records to load |
| ld_word_vld | input | 1 | Load word valid |
| ld_word | input | 16 | Load word |
| ld_done_clr | input | 1 | Clears the done flag |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | Sticky load-complete flag |
| rd_sel | input | 4 | Entry selected for reading |
| rd_w0 | output | 16 | Entry bytes 1:0 |
| rd_w1 | output | 16 | Entry bytes 3:2 |
| rd_w2 | output | 16 | Entry bytes 5:4 |

## Verification
The bench targets the places where the rule order matters:

- **All-ones address with both group and broadcast modes on.** A chain in the wrong order would flag it as broadcast.
- **Group address under promiscuous mode only.** A filter that tested promiscuous mode without the unicast check would accept it.
- **Loaded but disabled entries.** A design that ignored the enable mask would accept them.
- **A zero-count load.** This must change only the mask; a loader that checked its count after the first record would overwrite entry 0.
- **Junk in word 0 of every record.** A loader with an off-by-one word selection would store shifted bytes.
- **A second start command issued mid-load.** It must not restart the loader.

Random frames, drawn from table entries, broadcast, group and random addresses under random modes, are compared with a bench model of the chain.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam int ADDR_W = 48;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_ENTRY = 2'd1,
    LD_MASK  = 2'd2
  } ld_state_e;

  // group (multicast) bit: bit 0 of the first address byte
  function automatic logic is_group(input logic [ADDR_W-1:0] a);
    return a[0];
  endfunction

  function automatic logic is_all_ones(input logic [ADDR_W-1:0] a);
    return &a;
  endfunction

  // place a load word (sel 1..3) into its two-byte lane of an entry
  function automatic logic [ADDR_W-1:0] place_word(input logic [ADDR_W-1:0] cur,
                                                   input logic [1:0] sel,
                                                   input logic [WORD_W-1:0] w);
    logic [ADDR_W-1:0] r;
    r = cur;
    case (sel)
      2'd1: r[15:0]  = w;
      2'd2: r[31:16] = w;
      2'd3: r[47:32] = w;
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/daf_table.sv
module daf_table #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ADDR_W = daf_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              mask_we,
  input  logic [DEPTH-1:0]  mask_in,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DEPTH-1:0]  hit_vec,
  output logic [ADDR_W-1:0] rd_entry,
  output logic [DEPTH-1:0]  mask_q
);
  logic [ADDR_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        ent_q[g] <= daf_pkg::place_word(ent_q[g], wr_sel, wr_word);
      end
    end
    assign hit_vec[g] = mask_q[g] && (ent_q[g] == look_addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_in;
  end

  assign rd_entry = ent_q[rd_idx];
endmodule

// File: rtl/daf_loader.sv
module daf_loader #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              done_clr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [1:0]        wr_sel,
  output logic              mask_we,
  output logic              busy,
  output logic              done,
  output logic              entry_fin,
  output logic              load_fin
);
  import daf_pkg::*;

  ld_state_e        state_q;
  logic [1:0]       widx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             rec_end;

  assign rec_end   = word_vld && (widx_q == 2'd3);
  assign wr_en     = (state_q == LD_ENTRY) && word_vld && (widx_q != 2'd0);
  assign wr_idx    = idx_q;
  assign wr_sel    = widx_q;
  assign mask_we   = (state_q == LD_MASK) && word_vld && (widx_q == 2'd0);
  assign entry_fin = (state_q == LD_ENTRY) && rec_end;
  assign load_fin  = (state_q == LD_MASK) && rec_end;
  assign busy      = (state_q != LD_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      widx_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        LD_IDLE: begin
          if (start) begin
            cnt_q   <= count;
            idx_q   <= '0;
            widx_q  <= '0;
            state_q <= (count != '0) ? LD_ENTRY : LD_MASK;
          end
        end
        LD_ENTRY: begin
          if (word_vld) widx_q <= widx_q + 2'd1;
          if (entry_fin) begin
            cnt_q <= cnt_q - 1'b1;
            idx_q <= idx_q + 1'b1;
            if (cnt_q == CNT_W'(1)) state_q <= LD_MASK;
          end
        end
        LD_MASK: begin
          if (word_vld) widx_q <= widx_q + 2'd1;
          if (load_fin) state_q <= LD_IDLE;
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done <= 1'b0;
    else if (load_fin) done <= 1'b1;
    else if (done_clr) done <= 1'b0;
  end

  // the word itself is consumed by the table; unused here
  logic unused_word;
  assign unused_word = ^word;
endmodule

// File: rtl/daf_decide.sv
module daf_decide #(
  parameter int DEPTH = 16,
  localparam int ADDR_W = daf_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [ADDR_W-1:0] addr,
  input  logic              promisc,
  input  logic              all_mcast,
  input  logic              bcast_en,
  input  logic [DEPTH-1:0]  hit_vec,
  output logic              dec_vld,
  output logic              accept,
  output logic              mcast,
  output logic              bcast
);
  import daf_pkg::*;

  logic acc_d, mc_d, bc_d;

  always_comb begin
    acc_d = 1'b0;
    mc_d  = 1'b0;
    bc_d  = 1'b0;
    if (promisc && !is_group(addr)) begin
      acc_d = 1'b1;
    end else if (all_mcast && is_group(addr)) begin
      acc_d = 1'b1;
      mc_d  = 1'b1;
    end else if (bcast_en && is_all_ones(addr)) begin
      acc_d = 1'b1;
      bc_d  = 1'b1;
    end else begin
      acc_d = |hit_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld <= 1'b0;
      accept  <= 1'b0;
      mcast   <= 1'b0;
      bcast   <= 1'b0;
    end else begin
      dec_vld <= vld;
      accept  <= vld && acc_d;
      mcast   <= vld && mc_d;
      bcast   <= vld && bc_d;
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ADDR_W = daf_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_promisc,
  input  logic              cfg_all_mcast,
  input  logic              cfg_bcast,
  input  logic              cfg_in_reset,
  input  logic              dst_vld,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              dec_vld,
  output logic              dec_accept,
  output logic              dec_mcast,
  output logic              dec_bcast,
  input  logic              ld_start,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic              ld_word_vld,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              ld_done_clr,
  output logic              ld_busy,
  output logic              ld_done,
  input  logic [IDX_W-1:0]  rd_sel,
  output logic [15:0]       rd_w0,
  output logic [15:0]       rd_w1,
  output logic [15:0]       rd_w2
);
  logic              wr_en, mask_we, entry_fin, load_fin;
  logic [IDX_W-1:0]  wr_idx;
  logic [1:0]        wr_sel;
  logic [DEPTH-1:0]  hit_vec, mask_q;
  logic [ADDR_W-1:0] rd_entry;

  daf_loader #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_loader (
    .clk(clk), .rst_n(rst_n), .start(ld_start), .count(ld_count),
    .word_vld(ld_word_vld), .word(ld_word), .done_clr(ld_done_clr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .mask_we(mask_we),
    .busy(ld_busy), .done(ld_done), .entry_fin(entry_fin), .load_fin(load_fin)
  );

  daf_table #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .wr_word(ld_word), .mask_we(mask_we), .mask_in(ld_word[DEPTH-1:0]),
    .look_addr(dst_addr), .rd_idx(rd_sel), .hit_vec(hit_vec),
    .rd_entry(rd_entry), .mask_q(mask_q)
  );

  daf_decide #(.DEPTH(DEPTH)) u_decide (
    .clk(clk), .rst_n(rst_n), .vld(dst_vld), .addr(dst_addr),
    .promisc(cfg_promisc), .all_mcast(cfg_all_mcast), .bcast_en(cfg_bcast),
    .hit_vec(hit_vec), .dec_vld(dec_vld), .accept(dec_accept),
    .mcast(dec_mcast), .bcast(dec_bcast)
  );

  assign rd_w0 = cfg_in_reset ? rd_entry[15:0]  : 16'h0;
  assign rd_w1 = cfg_in_reset ? rd_entry[31:16] : 16'h0;
  assign rd_w2 = cfg_in_reset ? rd_entry[47:32] : 16'h0;
endmodule

// File: rtl/daf_checker.sv
module daf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_promisc,
  input logic        cfg_in_reset,
  input logic        dst_vld,
  input logic [47:0] dst_addr,
  input logic        dec_vld,
  input logic        dec_accept,
  input logic        dec_mcast,
  input logic        dec_bcast,
  input logic        ld_start,
  input logic        ld_busy,
  input logic        ld_done,
  input logic [15:0] rd_w0,
  input logic [15:0] rd_w1,
  input logic [15:0] rd_w2,
  input logic        load_fin
);
  a_r6_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dst_vld |=> dec_vld);
  a_r6_vld_only_after: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_vld |=> !dec_vld);
  a_r6_flag_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mcast || dec_bcast) |-> dec_accept);
  a_r2_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_mcast, dec_bcast}));
  a_r1_promisc_unicast: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_vld && cfg_promisc && !dst_addr[0]) |=> (dec_accept && !dec_mcast && !dec_bcast));
  a_r9_done_with_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_done) |-> $fell(ld_busy));
  a_r9_fin_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    load_fin |-> ld_busy);
  a_r9_start_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ld_start |=> ld_busy);
  a_r10_ports_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_in_reset |-> (rd_w0 == 16'h0 && rd_w1 == 16'h0 && rd_w2 == 16'h0));
endmodule

bind dest_addr_filter daf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_promisc(cfg_promisc), .cfg_in_reset(cfg_in_reset),
  .dst_vld(dst_vld), .dst_addr(dst_addr), .dec_vld(dec_vld), .dec_accept(dec_accept),
  .dec_mcast(dec_mcast), .dec_bcast(dec_bcast), .ld_start(ld_start),
  .ld_busy(ld_busy), .ld_done(ld_done), .rd_w0(rd_w0), .rd_w1(rd_w1),
  .rd_w2(rd_w2), .load_fin(load_fin)
);

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_promisc = 0, cfg_all_mcast = 0, cfg_bcast = 0, cfg_in_reset = 0;
  logic dst_vld = 0;
  logic [47:0] dst_addr = '0;
  logic dec_vld, dec_accept, dec_mcast, dec_bcast;
  logic ld_start = 0;
  logic [4:0] ld_count = '0;
  logic ld_word_vld = 0;
  logic [15:0] ld_word = '0;
  logic ld_done_clr = 0;
  logic ld_busy, ld_done;
  logic [3:0] rd_sel = '0;
  logic [15:0] rd_w0, rd_w1, rd_w2;

  int n_chk = 0, n_err = 0;
  logic [47:0] cam_m [16];
  logic [15:0] mask_m = '0;
  logic [47:0] pool [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  dest_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_promisc(cfg_promisc), .cfg_all_mcast(cfg_all_mcast),
    .cfg_bcast(cfg_bcast), .cfg_in_reset(cfg_in_reset), .dst_vld(dst_vld),
    .dst_addr(dst_addr), .dec_vld(dec_vld), .dec_accept(dec_accept),
    .dec_mcast(dec_mcast), .dec_bcast(dec_bcast), .ld_start(ld_start),
    .ld_count(ld_count), .ld_word_vld(ld_word_vld), .ld_word(ld_word),
    .ld_done_clr(ld_done_clr), .ld_busy(ld_busy), .ld_done(ld_done),
    .rd_sel(rd_sel), .rd_w0(rd_w0), .rd_w1(rd_w1), .rd_w2(rd_w2)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model of the decision chain: {accept, mcast, bcast}
  function automatic logic [2:0] model(input logic [47:0] a, input logic pr,
                                       input logic am, input logic bc);
    logic grp;
    grp = a[0];
    if (pr && !grp) return 3'b100;
    if (am && grp) return 3'b110;
    if (bc && a == {48{1'b1}}) return 3'b101;
    for (int i = 0; i < 16; i++)
      if (mask_m[i] && cam_m[i] == a) return 3'b100;
    return 3'b000;
  endfunction

  task automatic send_word(input logic [15:0] w, input bit gaps);
    if (gaps && ($urandom_range(0, 3) == 0)) begin
      @(negedge clk); ld_word_vld = 0; ld_word = 16'hdead;
    end
    @(negedge clk); ld_word_vld = 1; ld_word = w;
  endtask

  // load n entries from list (indices 0..n-1 of new_e), mask word m
  task automatic do_load(input int n, input logic [47:0] new_e [16], input logic [15:0] m,
                         input bit gaps, input bit extra_start);
    @(negedge clk); ld_done_clr = 1;
    @(negedge clk); ld_done_clr = 0; ld_start = 1; ld_count = 5'(n);
    @(negedge clk); ld_start = 0;
    check("R9 busy after start", {63'b0, ld_busy}, 64'h1);
    for (int e = 0; e < n; e++) begin
      send_word(16'($urandom), gaps);                 // word 0 skipped (R7)
      if (extra_start && e == 0) begin ld_start = 1; ld_count = 5'd9; end
      send_word(new_e[e][15:0], gaps);
      ld_start = 0;
      send_word(new_e[e][31:16], gaps);
      send_word(new_e[e][47:32], gaps);
      cam_m[e] = new_e[e];
    end
    send_word(m, gaps);
    send_word(16'($urandom), gaps);
    send_word(16'($urandom), gaps);
    send_word(16'($urandom), gaps);
    mask_m = m;
    @(negedge clk); ld_word_vld = 0;
    check("R9 done after mask record", {62'b0, ld_busy, ld_done}, 64'h1);
  endtask

  task automatic frame(input logic [47:0] a, input string tag);
    logic [2:0] e;
    e = model(a, cfg_promisc, cfg_all_mcast, cfg_bcast);
    @(negedge clk); dst_vld = 1; dst_addr = a;
    @(negedge clk); dst_vld = 0;
    check(tag, {60'b0, dec_vld, dec_accept, dec_mcast, dec_bcast}, {60'b0, 1'b1, e});
  endtask

  task automatic modes(input logic p, input logic m, input logic b);
    @(negedge clk); cfg_promisc = p; cfg_all_mcast = m; cfg_bcast = b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [47:0] ents [16];
    logic [47:0] u0, u1, u2;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 16; i++) cam_m[i] = '0;
    for (int i = 0; i < 16; i++) ents[i] = {16'($urandom), 32'($urandom)} & ~48'h1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    check("R11 reset outputs", {58'b0, ld_busy, ld_done, dec_vld, dec_accept, dec_mcast, dec_bcast}, 64'h0);
    frame(ents[0], "R11 empty table rejects");

    // R7 R8 R9: load three entries, enable 0 and 2
    do_load(3, ents, 16'h0005, 1'b1, 1'b1);
    // R9 start during busy ignored: load ended after 3 records
    check("R9 ignored restart, idle", {63'b0, ld_busy}, 64'h0);
    @(negedge clk); ld_done_clr = 0;
    check("R9 done is sticky", {63'b0, ld_done}, 64'h1);
    @(negedge clk); ld_done_clr = 1;
    @(negedge clk); ld_done_clr = 0;
    check("R9 done cleared", {63'b0, ld_done}, 64'h0);

    // R10: read ports
    @(negedge clk); cfg_in_reset = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); rd_sel = 4'(i);
      #1 check("R10 read entry", {16'b0, rd_w2, rd_w1, rd_w0}, {16'b0, ents[i]});
    end
    @(negedge clk); cfg_in_reset = 0;
    #1 check("R10 ports closed", {16'b0, rd_w2, rd_w1, rd_w0}, 64'h0);

    // R4 R5
    modes(0, 0, 0);
    frame(ents[0], "R4 enabled entry 0 accepts");
    frame(ents[2], "R4 enabled entry 2 accepts");
    frame(ents[1], "R5 disabled entry 1 rejects");
    frame(ents[0] ^ 48'h0100, "R4 near miss rejects");

    // R1
    u0 = {16'($urandom), 32'($urandom)} & ~48'h1;
    modes(1, 0, 0);
    frame(u0, "R1 promisc unicast accepts");
    frame(u0 | 48'h1, "R1 promisc group address rejects");
    // R2
    modes(0, 1, 0);
    frame(u0 | 48'h1, "R2 group address accepted as multicast");
    modes(0, 1, 1);
    frame({48{1'b1}}, "R2 all-ones under both modes is multicast");
    // R3
    modes(0, 0, 1);
    frame({48{1'b1}}, "R3 broadcast accepted");
    modes(0, 0, 0);
    frame({48{1'b1}}, "R3 broadcast off rejects");

    // R6: no strobe, no verdict
    @(negedge clk);
    @(negedge clk);
    check("R6 no verdict without strobe", {63'b0, dec_vld}, 64'h0);

    // R8: zero-count load only swaps mask
    do_load(0, ents, 16'h0002, 1'b0, 1'b0);
    frame(ents[1], "R8 zero count mask now enables entry 1");
    frame(ents[0], "R8 zero count entry 0 now disabled");

    // full-table load, then random traffic
    for (int i = 0; i < 16; i++) ents[i] = {16'($urandom), 32'($urandom)};
    u1 = 48'($urandom);
    u2 = 48'($urandom);
    do_load(16, ents, 16'($urandom), 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) pool[i] = ents[i];
    for (int i = 16; i < 32; i++) pool[i] = {16'($urandom), 32'($urandom)};
    pool[16] = {48{1'b1}}; pool[17] = u1; pool[18] = u2;
    for (int k = 0; k < 300; k++) begin
      logic [47:0] a;
      a = pool[$urandom_range(0, 31)];
      if ($urandom_range(0, 4) == 0) a[0] = ~a[0];
      modes(1'($urandom), 1'($urandom), 1'($urandom));
      frame(a, "R1 R2 R3 R4 R5 random frame vs model");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule